// File: doc/BRIEF.md
# NAND ECC Syndrome Checker and Corrector

This block checks one 256-byte chunk read from NAND flash. It takes the 3-byte Hamming code kept in the spare area and the 3-byte code computed again from the data just read. It XORs the two codes into a 24-bit syndrome and sorts the result into one of four cases by counting the set bits in that syndrome. The cases are: clean, a single flipped data bit that can be fixed, a fault inside the stored code itself, and damage that cannot be repaired. For a repairable error it reports the byte position and the bit position of the bad bit, together with a one-hot mask.

After a check, the data bytes are streamed through a read-back port, each one with its index. The byte whose index matches the reported position comes out with the faulty bit inverted. Every other byte passes through unchanged. The result of a check is held until the next check strobe, so the read-back stream can follow at any later time.

Top module: `eccSyndromeCorrector`

## Requirements
- R1: If the stored code equals the fresh code, the status is 2'b00 (clean), and the byte index, bit index and mask are all zero.
- R2: If the syndrome (stored XOR fresh) has exactly 11 bits set, the status is 2'b01 (data bit corrected).
- R3: If the syndrome has exactly 1 bit set, the status is 2'b10 (stored code damaged). The byte index, bit index and mask are zero, and read-back data passes through unchanged.
- R4: Any other syndrome bit count (2 to 10, or 12 to 24) gives status 2'b11 (uncorrectable), with the byte index, bit index and mask zero.
- R5: In the corrected case, byte index bits 3..0 are syndrome bits 7,5,3,1 in that order, and byte index bits 7..4 are syndrome bits 15,13,11,9 in that order.
- R6: In the corrected case, bit index bits 2..0 are syndrome bits 23,21,19 in that order, and the mask is 1 shifted left by the bit index.
- R7: Status, location and mask update on the first rising edge after checkStb is sampled high. statusValid is high for exactly that one cycle. Status, location and mask then hold until the next strobe.
- R8: outValid and outData follow rdValid by one cycle. outData is rdData XOR mask when the status is 2'b01 and rdIdx equals the byte index; otherwise outData equals rdData.
- R9: While reset is active, status is 2'b00, statusValid and outValid are 0, and the byte index, bit index and mask are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| checkStb | input | 1 | Starts a comparison of the two codes |
| storedCode | input | 24 | Code read from the spare area (byte 0 in bits 7..0) |
| freshCode | input | 24 | Code recomputed from the data read |
| rdValid | input | 1 | Read-back byte present |
| rdIdx | input | 8 | Index of the read-back byte within the chunk |
| rdData | input | 8 | Read-back byte |
| status | output | 2 | Result class: 00 clean, 01 corrected, 10 code-area error, 11 uncorrectable |
| statusValid | output | 1 | One-cycle pulse when a new result is available |
| errByte | output | 8 | Index of the faulty byte |
| errBit | output | 3 | Index of the faulty bit within that byte |
| corrMask | output | 8 | One-hot flip mask |
| outValid | output | 1 | Corrected byte present |
| outData | output | 8 | Byte after correction |

## Verification
The bench builds the block with its default geometry: 8 row-address bits and 3 column-address bits, which gives a 24-bit code, a weight of 11 for a repairable error and 256 byte positions. With this geometry every one of the 2048 single-bit data error positions can be injected exhaustively. Each injection is checked for location, mask and the flip on read-back, both at the matching byte and at a byte that does not match. All 24 single-bit code errors are also injected, along with random pairs of data errors, which always produce an even bit count that is neither 0 nor 11.

// File: rtl/eccChkPkg.sv
package eccChkPkg;

  typedef enum logic [1:0] {
    ST_CLEAN = 2'b00,
    ST_FIXED = 2'b01,
    ST_CODE  = 2'b10,
    ST_FATAL = 2'b11
  } eccStatus_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;  // latch location of the current syndrome
    logic flipEn;   // read-back byte may be corrected
  } eccCtrl_t;

endpackage

// File: rtl/eccChkData.sv
module eccChkData
  import eccChkPkg::*;
#(
  parameter int ROW_BITS = 8,
  parameter int COL_BITS = 3
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  eccCtrl_t                    ctrl,
  input  logic [2*(ROW_BITS+COL_BITS)+1:0] storedCode,
  input  logic [2*(ROW_BITS+COL_BITS)+1:0] freshCode,
  input  logic                        rdValid,
  input  logic [ROW_BITS-1:0]         rdIdx,
  input  logic [(1<<COL_BITS)-1:0]    rdData,
  output eccStatus_t                  synClass,
  output logic [ROW_BITS-1:0]         errByte,
  output logic [COL_BITS-1:0]         errBit,
  output logic [(1<<COL_BITS)-1:0]    corrMask,
  output logic                        outValid,
  output logic [(1<<COL_BITS)-1:0]    outData
);

  localparam int SYN_W      = 2*(ROW_BITS+COL_BITS) + 2;
  localparam int DATA_W     = 1 << COL_BITS;
  localparam int WEIGHT_W   = $clog2(SYN_W + 1);
  localparam int FIX_WEIGHT = ROW_BITS + COL_BITS;
  localparam int COL_BASE   = 2*ROW_BITS + 2;  // first column pair, past two pad bits

  logic [SYN_W-1:0]    syndrome;
  logic [WEIGHT_W-1:0] weight;
  logic [ROW_BITS-1:0] byteLoc;
  logic [COL_BITS-1:0] bitLoc;

  assign syndrome = storedCode ^ freshCode;
  assign weight   = WEIGHT_W'($countones(syndrome));

  // odd member of every parity pair carries one address bit
  for (genvar k = 0; k < ROW_BITS; k++) begin : gRowAddr
    assign byteLoc[k] = syndrome[2*k+1];
  end
  for (genvar j = 0; j < COL_BITS; j++) begin : gColAddr
    assign bitLoc[j] = syndrome[COL_BASE + 2*j + 1];
  end

  always_comb begin
    if (weight == '0)                         synClass = ST_CLEAN;
    else if (weight == WEIGHT_W'(FIX_WEIGHT)) synClass = ST_FIXED;
    else if (weight == WEIGHT_W'(1))          synClass = ST_CODE;
    else                                      synClass = ST_FATAL;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errByte  <= '0;
      errBit   <= '0;
      corrMask <= '0;
    end else if (ctrl.capture) begin
      if (synClass == ST_FIXED) begin
        errByte  <= byteLoc;
        errBit   <= bitLoc;
        corrMask <= DATA_W'(1) << bitLoc;
      end else begin
        errByte  <= '0;
        errBit   <= '0;
        corrMask <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData  <= '0;
    end else begin
      outValid <= rdValid;
      if (ctrl.flipEn && (rdIdx == errByte)) outData <= rdData ^ corrMask;
      else                                   outData <= rdData;
    end
  end

endmodule

// File: rtl/eccChkCtrl.sv
module eccChkCtrl
  import eccChkPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       checkStb,
  input  logic       rdValid,
  input  eccStatus_t synClass,
  output eccCtrl_t   ctrl,
  output eccStatus_t status,
  output logic       statusValid
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      status      <= ST_CLEAN;
      statusValid <= 1'b0;
    end else begin
      statusValid <= checkStb;
      if (checkStb) status <= synClass;
    end
  end

  always_comb begin
    ctrl.capture = checkStb;
    ctrl.flipEn  = rdValid && (status == ST_FIXED);
  end

endmodule

// File: rtl/eccSyndromeCorrector.sv
module eccSyndromeCorrector
  import eccChkPkg::*;
#(
  parameter int ROW_BITS = 8,
  parameter int COL_BITS = 3
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              checkStb,
  input  logic [2*(ROW_BITS+COL_BITS)+1:0]  storedCode,
  input  logic [2*(ROW_BITS+COL_BITS)+1:0]  freshCode,
  input  logic                              rdValid,
  input  logic [ROW_BITS-1:0]               rdIdx,
  input  logic [(1<<COL_BITS)-1:0]          rdData,
  output logic [1:0]                        status,
  output logic                              statusValid,
  output logic [ROW_BITS-1:0]               errByte,
  output logic [COL_BITS-1:0]               errBit,
  output logic [(1<<COL_BITS)-1:0]          corrMask,
  output logic                              outValid,
  output logic [(1<<COL_BITS)-1:0]          outData
);

  eccCtrl_t   ctrl;
  eccStatus_t synClass;
  eccStatus_t statusQ;

  eccChkCtrl ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .checkStb    (checkStb),
    .rdValid     (rdValid),
    .synClass    (synClass),
    .ctrl        (ctrl),
    .status      (statusQ),
    .statusValid (statusValid)
  );

  eccChkData #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) data_i (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .storedCode (storedCode),
    .freshCode  (freshCode),
    .rdValid    (rdValid),
    .rdIdx      (rdIdx),
    .rdData     (rdData),
    .synClass   (synClass),
    .errByte    (errByte),
    .errBit     (errBit),
    .corrMask   (corrMask),
    .outValid   (outValid),
    .outData    (outData)
  );

  assign status = statusQ;

endmodule

// File: rtl/eccSyndromeCorrector_chk.sv
module eccSyndromeCorrector_chk #(
  parameter int ROW_BITS = 8,
  parameter int COL_BITS = 3
) (
  input logic                             clk,
  input logic                             rstN,
  input logic                             checkStb,
  input logic [2*(ROW_BITS+COL_BITS)+1:0] storedCode,
  input logic [2*(ROW_BITS+COL_BITS)+1:0] freshCode,
  input logic                             rdValid,
  input logic [ROW_BITS-1:0]              rdIdx,
  input logic [(1<<COL_BITS)-1:0]         rdData,
  input logic [1:0]                       status,
  input logic                             statusValid,
  input logic [ROW_BITS-1:0]              errByte,
  input logic [COL_BITS-1:0]              errBit,
  input logic [(1<<COL_BITS)-1:0]         corrMask,
  input logic                             outValid,
  input logic [(1<<COL_BITS)-1:0]         outData
);

  assert_clean_R1: assert property (@(posedge clk) disable iff (!rstN)
    (checkStb && storedCode == freshCode) |=> (status == 2'b00 && corrMask == '0));

  assert_code_area_R3: assert property (@(posedge clk) disable iff (!rstN)
    (checkStb && $countones(storedCode ^ freshCode) == 1) |=> (status == 2'b10));

  assert_no_loc_unless_fixed_R4: assert property (@(posedge clk) disable iff (!rstN)
    (status != 2'b01) |-> (corrMask == '0 && errByte == '0 && errBit == '0));

  assert_mask_onehot_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(corrMask));

  assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    checkStb |=> statusValid);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !checkStb |=> ($stable(status) && $stable(corrMask) && !statusValid));

  assert_out_valid_R8: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> outValid);

  assert_pass_through_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && status != 2'b01) |=> (outData == $past(rdData)));

endmodule

bind eccSyndromeCorrector eccSyndromeCorrector_chk #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) chk_i (
  .clk(clk), .rstN(rstN), .checkStb(checkStb), .storedCode(storedCode),
  .freshCode(freshCode), .rdValid(rdValid), .rdIdx(rdIdx), .rdData(rdData),
  .status(status), .statusValid(statusValid), .errByte(errByte),
  .errBit(errBit), .corrMask(corrMask), .outValid(outValid), .outData(outData)
);

// File: tb/eccSyndromeCorrector_tb_top.sv
module eccSyndromeCorrector_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        checkStb = 1'b0;
  logic [23:0] storedCode = '0;
  logic [23:0] freshCode = '0;
  logic        rdValid = 1'b0;
  logic [7:0]  rdIdx = '0;
  logic [7:0]  rdData = '0;
  logic [1:0]  status;
  logic        statusValid;
  logic [7:0]  errByte;
  logic [2:0]  errBit;
  logic [7:0]  corrMask;
  logic        outValid;
  logic [7:0]  outData;

  int testsRun = 0;
  int testsFailed = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  eccSyndromeCorrector dut_i (
    .clk(clk), .rstN(rstN), .checkStb(checkStb), .storedCode(storedCode),
    .freshCode(freshCode), .rdValid(rdValid), .rdIdx(rdIdx), .rdData(rdData),
    .status(status), .statusValid(statusValid), .errByte(errByte),
    .errBit(errBit), .corrMask(corrMask), .outValid(outValid), .outData(outData)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // syndrome of a single flipped data bit at byte b, bit c
  function automatic logic [23:0] singleSyn(input int b, input int c);
    logic [23:0] s = '0;
    for (int k = 0; k < 8; k++) s[b[k] ? 2*k+1 : 2*k] = 1'b1;
    for (int j = 0; j < 3; j++) s[c[j] ? 18+2*j+1 : 18+2*j] = 1'b1;
    return s;
  endfunction

  task automatic strobe(input logic [23:0] st, input logic [23:0] fr);
    @(negedge clk);
    checkStb = 1'b1; storedCode = st; freshCode = fr;
    @(negedge clk);
    checkStb = 1'b0;
  endtask

  task automatic readBack(input logic [7:0] idx, input logic [7:0] d, output logic [7:0] q, output logic v);
    @(negedge clk);
    rdValid = 1'b1; rdIdx = idx; rdData = d;
    @(negedge clk);
    rdValid = 1'b0;
    q = outData; v = outValid;
  endtask

  task automatic testReset();
    check(status == 2'b00 && !statusValid && !outValid && errByte == 0 && errBit == 0 && corrMask == 0,
          "R9 reset state", {status, statusValid, outValid, errByte, errBit, corrMask}, 0);
  endtask

  task automatic testClean();
    logic [7:0] q; logic v;
    for (int n = 0; n < 8; n++) begin
      logic [23:0] st = 24'($urandom);
      strobe(st, st);
      check(status == 2'b00 && statusValid, "R1 clean status", {status, statusValid}, 3'b001);
      check(errByte == 0 && errBit == 0 && corrMask == 0, "R1 clean location", {errByte, errBit, corrMask}, 0);
      readBack(8'(n), 8'hA5, q, v);
      check(v && q == 8'hA5, "R8 clean pass-through", q, 8'hA5);
    end
  endtask

  task automatic testAllSingle();
    logic [7:0] q; logic v;
    for (int b = 0; b < 256; b++) begin
      for (int c = 0; c < 8; c++) begin
        logic [23:0] st = 24'($urandom);
        logic [7:0]  d  = 8'($urandom);
        bit ok;
        strobe(st, st ^ singleSyn(b, c));
        ok = (status == 2'b01) && statusValid;
        check(ok, "R2 corrected status", status, 2'b01);
        ok = (errByte == 8'(b)) && (errBit == 3'(c)) && (corrMask == (8'd1 << c));
        check(ok, "R5 R6 location", {errByte, errBit, corrMask}, {8'(b), 3'(c), 8'd1 << c});
        readBack(8'(b), d, q, v);
        check(v && q == (d ^ (8'd1 << c)), "R8 flip at index", q, d ^ (8'd1 << c));
        readBack(8'(b ^ 1), d, q, v);
        check(v && q == d, "R8 no flip elsewhere", q, d);
      end
    end
  endtask

  task automatic testCodeError();
    logic [7:0] q; logic v;
    for (int p = 0; p < 24; p++) begin
      logic [23:0] st = 24'($urandom);
      strobe(st, st ^ (24'd1 << p));
      check(status == 2'b10, "R3 code-area status", status, 2'b10);
      check(errByte == 0 && errBit == 0 && corrMask == 0, "R3 no location", {errByte, errBit, corrMask}, 0);
      readBack(8'h00, 8'h3C, q, v);
      check(v && q == 8'h3C, "R3 data untouched", q, 8'h3C);
    end
  endtask

  task automatic testDouble();
    for (int n = 0; n < 200; n++) begin
      int b1 = int'($urandom_range(255)), c1 = int'($urandom_range(7));
      int b2 = int'($urandom_range(255)), c2 = int'($urandom_range(7));
      logic [23:0] st = 24'($urandom);
      if (b1 == b2 && c1 == c2) b2 = (b2 + 1) % 256;
      strobe(st, st ^ singleSyn(b1, c1) ^ singleSyn(b2, c2));
      check(status == 2'b11 && corrMask == 0, "R4 double error", status, 2'b11);
    end
  endtask

  task automatic testOtherWeights();
    logic [23:0] pats [4] = '{24'h000003, 24'hFFFFFF, 24'h000FFF, 24'h0007FE};
    // weights 2, 24, 12, 10
    for (int n = 0; n < 4; n++) begin
      strobe(24'h5A5A5A, 24'h5A5A5A ^ pats[n]);
      check(status == 2'b11, "R4 other weight", status, 2'b11);
    end
  endtask

  task automatic testHold();
    strobe(24'h123456, 24'h123456 ^ singleSyn(200, 5));
    check(statusValid, "R7 pulse on result", statusValid, 1);
    repeat (3) @(negedge clk);
    check(!statusValid && status == 2'b01 && errByte == 8'd200 && errBit == 3'd5,
          "R7 hold without strobe", {statusValid, status, errByte, errBit}, {1'b0, 2'b01, 8'd200, 3'd5});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testClean();
    testAllSingle();
    testCodeError();
    testDouble();
    testOtherWeights();
    testHold();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule